// File: doc/BRIEF.md
# PHY Management Master with Emulated PHY Register File

This block lets a host processor read and write the management registers of an Ethernet PHY through four word-wide host registers. The host loads a data word, then writes a command word that names a PHY address, a register number and an operation, with a start bit set. The block then performs one single-register transaction against an internal 32-entry PHY register model. Serial bit timing on the management pins is not modelled. A transaction finishes two clock edges after the command write, and the read-data register then holds the result.

The PHY model answers at one fixed bus address, set by a parameter. Most of its registers are plain 16-bit storage. The basic status, link-partner ability and diagnostic registers are not stored: they are computed at read time from a link input and from the stored advertisement register. Any other PHY address behaves as an empty bus position. A control register holds an enable bit and a clock divider. A warning output flags the case where the interface is enabled with a zero divider.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command word places the PHY address in bits 28:24, the register number in bits 20:16, the operation in bits 15:14 and the start flag in bit 11. All other bits have no effect on the transaction. A command written with bit 11 clear starts nothing.
- R2: Operation 1 writes the low 16 bits of the write-data register into the addressed PHY register. Operation 2 loads the addressed PHY register, zero-extended, into the read-data register. The result is visible after the second rising edge following the command write.
- R3: Reading the command register returns the last written command with bit 7 forced to 1 (ready).
- R4: A started command with operation 0 or 3 changes no PHY register and leaves the read-data register unchanged. It drives `op_err` high for exactly the one cycle after the command write.
- R5: A read from any PHY address other than `PHY_ADDR` (default 7) returns 0x0000FFFF. A write to such an address changes nothing.
- R6: After reset the PHY registers read reg0 = 0x3100, reg2 = 0x0300, reg3 = 0xE400 and reg4 = 0x01E1. Every other stored register reads 0.
- R7: reg1 reads 0x782E (bits 14,13,12,11,5,3,2,1) while `link_up` is 1, and 0 while it is 0.
- R8: reg5 reads 0x4000 | (reg4 & 0x01E0) | 0x0001.
- R9: reg17 always reads 0x8000.
- R10: While `link_up` is 1, reg18 bit 10 = reg4[7] | reg4[8] and bit 11 = reg4[6] | reg4[8], with all other bits 0. While `link_up` is 0, reg18 reads 0.
- R11: The control register keeps only bits 6:0 and reads the others as 0. Bit 6 is the enable and bits 5:0 are the divider. `div_warn` is 1 exactly while enable is 1 and the divider is 0.
- R12: Host select 0 is the control register, 1 the command register, 2 the write-data register and 3 the read-data register. All four are host-writable and reset to 0. A completing read has priority over a host write to the read-data register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select, used for both writes and reads |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read-back of the selected host register (combinational) |
| link_up | input | 1 | Link state presented by the PHY model |
| op_err | output | 1 | One-cycle pulse for a started command with an invalid operation |
| div_warn | output | 1 | Interface enabled with a zero clock divider |

## Verification
The hardest case to reach is a computed PHY register that depends on stored state written earlier through the same transaction path. The diagnostic and partner-ability values only change after a completed write to the advertisement register, and the link input must be toggled in between. The stimulus therefore chains full write transactions to reg4 with several advertisement patterns, toggles `link_up`, and then reads reg1, reg5 and reg18. A behavioural model tracks every stored PHY register, and each read is checked against it. Commands with junk in the unused bits, commands without the start bit and commands to an empty bus address are placed between valid ones, so that a leak into the read-data register would show up.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared field positions, selectors and request type for the
// PHY management master. Assumes a 32-bit host word and 16-bit PHY data.
package mdio_mgmt_pkg;
    localparam int HOST_DW       = 32;
    localparam int PHY_DW        = 16;
    localparam int FIELD_W       = 5;
    localparam int CMD_PHY_LSB   = 24;
    localparam int CMD_REG_LSB   = 16;
    localparam int CMD_OP_LSB    = 14;
    localparam int CMD_GO_BIT    = 11;
    localparam int CMD_READY_BIT = 7;
    localparam int CTL_W         = 7;
    localparam int CTL_EN_BIT    = 6;
    localparam int DIV_W         = 6;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_WDAT = 2'd2,
        SEL_RDAT = 2'd3
    } host_sel_e;

    typedef enum logic [1:0] {
        OPC_RSV0  = 2'd0,
        OPC_WRITE = 2'd1,
        OPC_READ  = 2'd2,
        OPC_RSV3  = 2'd3
    } mgmt_op_e;

    typedef struct packed {
        logic                valid;
        mgmt_op_e            op;
        logic [FIELD_W-1:0]  phy;
        logic [FIELD_W-1:0]  regn;
        logic [PHY_DW-1:0]   data;
    } mgmt_req_t;
endpackage

// File: rtl/phy_regfile.sv
// Module: emulated PHY management register file.
// Stores N_REGS words. reg1, reg5, reg17 and reg18 are computed at read
// time from link_up and the stored advertisement register (reg4).
// Assumes N_REGS > 18 so all fixed indices exist.
module phy_regfile
    import mdio_mgmt_pkg::*;
#(
    parameter int N_REGS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      link_up,
    input  logic                      wr_en,
    input  logic [$clog2(N_REGS)-1:0] regn,
    input  logic [PHY_DW-1:0]         wr_data,
    output logic [PHY_DW-1:0]         rd_data
);
    localparam int AW       = $clog2(N_REGS);
    localparam int IDX_STAT = 1;
    localparam int IDX_ADV  = 4;
    localparam int IDX_LPA  = 5;
    localparam int IDX_FIX  = 17;
    localparam int IDX_DIAG = 18;

    localparam logic [PHY_DW-1:0] STAT_LINK = 16'h782E;
    localparam logic [PHY_DW-1:0] LPA_BASE  = 16'h4001;
    localparam logic [PHY_DW-1:0] ADV_MASK  = 16'h01E0;
    localparam logic [PHY_DW-1:0] FIX_VAL   = 16'h8000;

    // Reset value of each stored entry.
    function automatic logic [PHY_DW-1:0] init_val(input int idx);
        case (idx)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return '0;
        endcase
    endfunction

    logic [PHY_DW-1:0] mem [N_REGS];
    logic [PHY_DW-1:0] adv;
    logic              spd_hi;
    logic              full_dup;

    genvar gi;
    generate
        for (gi = 0; gi < N_REGS; gi++) begin : g_entry
            localparam logic [PHY_DW-1:0] RV = init_val(gi);
            // Purpose: hold one stored PHY register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[gi] <= RV;
                else if (wr_en && regn == AW'(gi))
                    mem[gi] <= wr_data;
            end
        end
    endgenerate

    assign adv      = mem[IDX_ADV];
    assign spd_hi   = adv[7] | adv[8];
    assign full_dup = adv[6] | adv[8];

    // Purpose: select stored or computed read value.
    always_comb begin
        case (regn)
            AW'(IDX_STAT): rd_data = link_up ? STAT_LINK : '0;
            AW'(IDX_LPA):  rd_data = LPA_BASE | (adv & ADV_MASK);
            AW'(IDX_FIX):  rd_data = FIX_VAL;
            AW'(IDX_DIAG): rd_data = link_up ? {4'b0, full_dup, spd_hi, 10'b0} : '0;
            default:       rd_data = mem[regn];
        endcase
    end
endmodule

// File: rtl/mgmt_host_regs.sv
// Module: host-visible registers of the management master.
// Decodes command writes into a transaction request and flags invalid
// operations. A completing read has priority over a host write to the
// read-data register. Assumes one host access per cycle.
module mgmt_host_regs
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         sel,
    input  logic [HOST_DW-1:0] wdata,
    output logic [HOST_DW-1:0] rdata,
    input  logic               res_load,
    input  logic [HOST_DW-1:0] res_value,
    output logic [CTL_W-1:0]   ctl_q,
    output mgmt_req_t          req,
    output logic               bad_op
);
    logic [HOST_DW-1:0] cmd_q;
    logic [HOST_DW-1:0] wdat_q;
    logic [HOST_DW-1:0] rdat_q;
    logic               go;
    mgmt_op_e           op;

    // Purpose: control, command and write-data register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            cmd_q  <= '0;
            wdat_q <= '0;
        end else if (wr_en) begin
            case (host_sel_e'(sel))
                SEL_CTL:  ctl_q  <= wdata[CTL_W-1:0];
                SEL_CMD:  cmd_q  <= wdata;
                SEL_WDAT: wdat_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: read-data register, transaction result wins over host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdat_q <= '0;
        else if (res_load)
            rdat_q <= res_value;
        else if (wr_en && host_sel_e'(sel) == SEL_RDAT)
            rdat_q <= wdata;
    end

    assign go = wr_en && host_sel_e'(sel) == SEL_CMD && wdata[CMD_GO_BIT];
    assign op = mgmt_op_e'(wdata[CMD_OP_LSB +: 2]);

    // Purpose: build the transaction request from a command write.
    always_comb begin
        req.valid = go && (op == OPC_WRITE || op == OPC_READ);
        req.op    = op;
        req.phy   = wdata[CMD_PHY_LSB +: FIELD_W];
        req.regn  = wdata[CMD_REG_LSB +: FIELD_W];
        req.data  = wdat_q[PHY_DW-1:0];
        bad_op    = go && !(op == OPC_WRITE || op == OPC_READ);
    end

    // Purpose: host read-back mux.
    always_comb begin
        case (host_sel_e'(sel))
            SEL_CTL:  rdata = {{(HOST_DW-CTL_W){1'b0}}, ctl_q};
            SEL_CMD:  rdata = cmd_q | (HOST_DW'(1) << CMD_READY_BIT);
            SEL_WDAT: rdata = wdat_q;
            default:  rdata = rdat_q;
        endcase
    end
endmodule

// File: rtl/mgmt_xact_engine.sv
// Module: one-stage transaction engine. Registers a request, then in the
// following cycle drives the PHY write or captures the PHY read. Addresses
// other than PHY_ADDR see an empty bus: reads give all ones, writes drop.
module mgmt_xact_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mgmt_req_t          req_in,
    input  logic               bad_op_in,
    input  logic [PHY_DW-1:0]  phy_rdata,
    output logic               phy_we,
    output logic [FIELD_W-1:0] phy_regn,
    output logic [PHY_DW-1:0]  phy_wdata,
    output logic [FIELD_W-1:0] exec_phy,
    output logic               res_load,
    output logic [HOST_DW-1:0] res_value,
    output logic               op_err
);
    localparam logic [FIELD_W-1:0] OWN_ADDR = FIELD_W'(PHY_ADDR);
    localparam logic [HOST_DW-1:0] EMPTY_RD = HOST_DW'(16'hFFFF);

    mgmt_req_t pend;
    logic      hit;

    // Purpose: hold the request for its execution cycle and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            op_err <= 1'b0;
        end else begin
            pend   <= req_in;
            op_err <= bad_op_in;
        end
    end

    assign hit       = pend.phy == OWN_ADDR;
    assign phy_we    = pend.valid && pend.op == OPC_WRITE && hit;
    assign phy_regn  = pend.regn;
    assign phy_wdata = pend.data;
    assign exec_phy  = pend.phy;
    assign res_load  = pend.valid && pend.op == OPC_READ;
    assign res_value = hit ? {{(HOST_DW-PHY_DW){1'b0}}, phy_rdata} : EMPTY_RD;
endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: top of the PHY management master with its emulated PHY.
// Host registers feed a one-stage engine that accesses the PHY model.
// Assumes a synchronous active-low reset and one host access per cycle.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 7,
    parameter int N_REGS   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        link_up,
    output logic        op_err,
    output logic        div_warn
);
    logic [CTL_W-1:0]   ctl_q;
    mgmt_req_t          req;
    logic               bad_op;
    logic               res_load;
    logic [HOST_DW-1:0] res_value;
    logic               phy_we;
    logic [FIELD_W-1:0] phy_regn;
    logic [PHY_DW-1:0]  phy_wdata;
    logic [PHY_DW-1:0]  phy_rdata;
    logic [FIELD_W-1:0] exec_phy;

    mgmt_host_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .sel(host_sel),
        .wdata(host_wdata), .rdata(host_rdata), .res_load(res_load),
        .res_value(res_value), .ctl_q(ctl_q), .req(req), .bad_op(bad_op)
    );

    mgmt_xact_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .req_in(req), .bad_op_in(bad_op),
        .phy_rdata(phy_rdata), .phy_we(phy_we), .phy_regn(phy_regn),
        .phy_wdata(phy_wdata), .exec_phy(exec_phy), .res_load(res_load),
        .res_value(res_value), .op_err(op_err)
    );

    phy_regfile #(.N_REGS(N_REGS)) u_phy (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(phy_we),
        .regn(phy_regn[$clog2(N_REGS)-1:0]), .wr_data(phy_wdata),
        .rd_data(phy_rdata)
    );

    assign div_warn = ctl_q[CTL_EN_BIT] && ctl_q[DIV_W-1:0] == '0;
endmodule

// File: rtl/mdio_mgmt_checker.sv
// Module: assertion checker bound to the management master top.
module mdio_mgmt_checker #(
    parameter int PHY_ADDR = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [1:0]  host_sel,
    input logic        cmd_go,
    input logic [1:0]  cmd_op,
    input logic        ctl_en,
    input logic [5:0]  ctl_div,
    input logic        rdy_bit,
    input logic        op_err,
    input logic        div_warn,
    input logic        res_load,
    input logic [31:0] res_value,
    input logic        phy_we,
    input logic [4:0]  exec_phy
);
    logic cmd_wr;
    logic bad_start;
    logic rd_start;
    assign cmd_wr    = host_wr && host_sel == 2'd1;
    assign bad_start = cmd_wr && cmd_go && (cmd_op == 2'd0 || cmd_op == 2'd3);
    assign rd_start  = cmd_wr && cmd_go && cmd_op == 2'd2;

    AST_CMD_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel == 2'd1 |-> rdy_bit); // R3
    AST_ERR_ONLY_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_err) |-> $past(bad_start)); // R4
    AST_BAD_OP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_start |=> !res_load && !phy_we && op_err); // R4
    AST_READ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> res_load); // R2
    AST_NO_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_go) |=> !res_load && !phy_we && !op_err); // R1
    AST_EMPTY_ADDR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && exec_phy != 5'(PHY_ADDR)) |-> res_value == 32'h0000FFFF); // R5
    AST_DIV_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0 && ctl_en && ctl_div == 6'd0) |=> div_warn); // R11
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.PHY_ADDR(PHY_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .cmd_go(host_wdata[11]), .cmd_op(host_wdata[15:14]),
    .ctl_en(host_wdata[6]), .ctl_div(host_wdata[5:0]),
    .rdy_bit(host_rdata[7]), .op_err(op_err), .div_warn(div_warn),
    .res_load(res_load), .res_value(res_value), .phy_we(phy_we),
    .exec_phy(exec_phy)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        link_up = 1'b1;
    logic        op_err;
    logic        div_warn;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mdio_mgmt_master u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .link_up(link_up),
        .op_err(op_err), .div_warn(div_warn)
    );

    // Behavioural reference model
    logic [15:0] m_mem [32];
    logic [6:0]  m_ctl;
    logic [31:0] m_cmd, m_wd, m_rd;
    bit          m_err;
    bit          p_v;
    int          p_op, p_phy, p_reg;
    logic [15:0] p_dat;

    function automatic logic [15:0] m_phy_read(int r);
        logic [15:0] a;
        a = m_mem[4];
        case (r)
            1:  return link_up ? 16'h782E : 16'h0;
            5:  return 16'h4001 | (a & 16'h01E0);
            17: return 16'h8000;
            18: return link_up ? {4'b0, a[6] | a[8], a[7] | a[8], 10'b0} : 16'h0;
            default: return m_mem[r];
        endcase
    endfunction

    always @(posedge clk) begin
        bit rl;
        rl = 0;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_mem[i] = 16'h0;
            m_mem[0] = 16'h3100; m_mem[2] = 16'h0300;
            m_mem[3] = 16'hE400; m_mem[4] = 16'h01E1;
            m_ctl = '0; m_cmd = '0; m_wd = '0; m_rd = '0; m_err = 0; p_v = 0;
        end else begin
            if (p_v) begin
                if (p_op == 1 && p_phy == 7) m_mem[p_reg] = p_dat;
                if (p_op == 2) begin
                    rl = 1;
                    m_rd = (p_phy == 7) ? {16'h0, m_phy_read(p_reg)} : 32'h0000FFFF;
                end
            end
            m_err = host_wr && host_sel == 2'd1 && host_wdata[11] &&
                    !(host_wdata[15:14] == 2'd1 || host_wdata[15:14] == 2'd2);
            p_v = 0;
            if (host_wr) begin
                case (host_sel)
                    2'd0: m_ctl = host_wdata[6:0];
                    2'd1: begin
                        m_cmd = host_wdata;
                        if (host_wdata[11] && (host_wdata[15:14] == 2'd1 ||
                                               host_wdata[15:14] == 2'd2)) begin
                            p_v   = 1;
                            p_op  = int'(host_wdata[15:14]);
                            p_phy = int'(host_wdata[28:24]);
                            p_reg = int'(host_wdata[20:16]);
                            p_dat = m_wd[15:0];
                        end
                    end
                    2'd2: m_wd = host_wdata;
                    default: if (!rl) m_rd = host_wdata;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            case (host_sel)
                2'd0: chk("R11 ctl readback", host_rdata, {25'b0, m_ctl});
                2'd1: chk("R3 cmd readback", host_rdata, m_cmd | 32'h80);
                2'd2: chk("R12 wdata readback", host_rdata, m_wd);
                default: chk("R2 rdata readback", host_rdata, m_rd);
            endcase
            chk("R4 op_err", {31'b0, op_err}, {31'b0, m_err});
            chk("R11 div_warn", {31'b0, div_warn},
                {31'b0, m_ctl[6] && m_ctl[5:0] == 6'd0});
        end
    end

    task automatic hwrite(input logic [1:0] s, input logic [31:0] d);
        host_wr = 1'b1; host_sel = s; host_wdata = d;
        @(posedge clk); #2;
        host_wr = 1'b0;
    endtask

    function automatic logic [31:0] cmdw(input int op, input int phy, input int r);
        return {3'b0, 5'(phy), 3'b0, 5'(r), 2'(op), 2'b0, 1'b1, 11'b0};
    endfunction

    task automatic xact(input logic [31:0] w);
        hwrite(2'd1, w);
        @(posedge clk); #2;
    endtask

    task automatic phy_rd(input int phy, input int r, output logic [31:0] v);
        xact(cmdw(2, phy, r));
        host_sel = 2'd3; #1;
        v = host_rdata;
    endtask

    task automatic phy_wr(input int phy, input int r, input logic [15:0] d);
        hwrite(2'd2, {16'h0, d});
        xact(cmdw(1, phy, r));
    endtask

    task automatic peek(input logic [1:0] s, output logic [31:0] v);
        host_sel = s; #1; v = host_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        peek(2'd1, v); chk("R3 R12 reset cmd", v, 32'h80);
        peek(2'd0, v); chk("R12 reset ctl", v, 32'h0);
        peek(2'd2, v); chk("R12 reset wdata", v, 32'h0);
        peek(2'd3, v); chk("R12 reset rdata", v, 32'h0);

        phy_rd(7, 0, v);  chk("R6 reg0", v, 32'h3100);
        phy_rd(7, 2, v);  chk("R6 reg2", v, 32'h0300);
        phy_rd(7, 3, v);  chk("R6 reg3", v, 32'hE400);
        phy_rd(7, 4, v);  chk("R6 reg4", v, 32'h01E1);
        phy_rd(7, 9, v);  chk("R6 reg9", v, 32'h0);
        phy_rd(7, 1, v);  chk("R7 reg1 link up", v, 32'h782E);
        phy_rd(7, 5, v);  chk("R8 reg5 default", v, 32'h41E1);
        phy_rd(7, 17, v); chk("R9 reg17", v, 32'h8000);
        phy_rd(7, 18, v); chk("R10 reg18 default", v, 32'h0C00);

        link_up = 1'b0;
        phy_rd(7, 1, v);  chk("R7 reg1 link down", v, 32'h0);
        phy_rd(7, 18, v); chk("R10 reg18 link down", v, 32'h0);
        link_up = 1'b1;

        phy_wr(7, 4, 16'h0041);
        phy_rd(7, 4, v);  chk("R2 reg4 write", v, 32'h0041);
        phy_rd(7, 18, v); chk("R10 reg18 10full", v, 32'h0800);
        phy_rd(7, 5, v);  chk("R8 reg5 10full", v, 32'h4041);
        phy_wr(7, 4, 16'h0081);
        phy_rd(7, 18, v); chk("R10 reg18 100half", v, 32'h0400);
        phy_rd(7, 5, v);  chk("R8 reg5 100half", v, 32'h4081);
        phy_wr(7, 4, 16'h0101);
        phy_rd(7, 18, v); chk("R10 reg18 100full", v, 32'h0C00);
        phy_wr(7, 4, 16'h0021);
        phy_rd(7, 18, v); chk("R10 reg18 10half", v, 32'h0);
        phy_rd(7, 5, v);  chk("R8 reg5 10half", v, 32'h4021);

        phy_rd(3, 0, v);  chk("R5 empty addr read", v, 32'h0000FFFF);
        phy_wr(3, 4, 16'h1234);
        phy_rd(7, 4, v);  chk("R5 empty addr write ignored", v, 32'h0021);

        phy_wr(7, 9, 16'hBEEF);
        phy_rd(7, 9, v);  chk("R2 reg9 write/read", v, 32'hBEEF);
        phy_wr(7, 31, 16'h5A5A);
        phy_rd(7, 31, v); chk("R2 reg31 write/read", v, 32'h5A5A);

        xact(cmdw(2, 7, 2) | 32'hE0E0_3000);
        peek(2'd3, v);    chk("R1 junk bits ignored", v, 32'h0300);

        hwrite(2'd3, 32'hCAFE_0001);
        hwrite(2'd1, cmdw(3, 7, 17));
        chk("R4 op_err pulse", {31'b0, op_err}, 32'h1);
        @(posedge clk); #2;
        chk("R4 op_err single cycle", {31'b0, op_err}, 32'h0);
        peek(2'd3, v);    chk("R4 rdata kept", v, 32'hCAFE_0001);
        hwrite(2'd2, 32'h0000_7777);
        xact(cmdw(0, 7, 9));
        phy_rd(7, 9, v);  chk("R4 op0 no write", v, 32'hBEEF);

        hwrite(2'd3, 32'h1111_2222);
        xact(cmdw(2, 7, 17) & ~32'h800);
        peek(2'd3, v);    chk("R1 no start bit", v, 32'h1111_2222);

        hwrite(2'd0, 32'hFFFF_FF40);
        peek(2'd0, v);    chk("R11 ctl masked", v, 32'h40);
        chk("R11 warn zero div", {31'b0, div_warn}, 32'h1);
        hwrite(2'd0, 32'h45);
        chk("R11 warn nonzero div", {31'b0, div_warn}, 32'h0);
        hwrite(2'd0, 32'h0);
        chk("R11 warn disabled", {31'b0, div_warn}, 32'h0);

        hwrite(2'd2, 32'hA5A5_5A5A);
        peek(2'd2, v);    chk("R12 wdata reg", v, 32'hA5A5_5A5A);

        repeat (3) @(posedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule